// File: doc/BRIEF.md
# Banked GPIO and Pin Function Register File

This block is a memory-mapped controller for a parameterised set of general-purpose pins. The pins are grouped into banks of 32. Each pin has an output value, an output enable and a 3-bit function code. The output value can be changed by setting bits, by clearing bits, or by writing the whole word. Software reads back the pin levels through a two-flop synchronizer.

The register layout grows with the pin count. A stride equal to the number of banks scales every base offset, so one register holds one word per bank at consecutive addresses. The function code of each pin is split across three bit-planes. The three plane words of a bank sit next to each other. When a pin has function code 0 it is a plain GPIO, and its output and enable registers drive the pad. Any other code gives the pin to an alternate function, and the GPIO drive outputs for that pin are held at 0.

Top module: `pin_bank_ctrl`

## Requirements
- R1: While reset is asserted and after reset, every output value, every output enable, every function code and `rdata_o` are 0.
- R2: The set register of bank b sits at byte address 4·b. Each 1 written drives the output of pin 32·b+i high, and each 0 written leaves that pin unchanged. A read of this register returns the current output value of the bank.
- R3: The clear register of bank b sits at 4·S+4·b, where S = 1+(NUM_PINS−1)/32. Each 1 written drives the output low, and each 0 written leaves the pin unchanged. A read returns the current output value of the bank.
- R4: The output register of bank b sits at 8·S+4·b. A write replaces all output bits of the bank, and a read returns them.
- R5: The enable register of bank b sits at 16·S+4·b. A 1 makes the pin an output and a 0 makes it an input. The register can be read back.
- R6: The input register of bank b sits at 12·S+4·b. It returns the pin levels through a two-flop synchronizer. A level that changes before clock edge k is seen by a read issued at edge k+2, and not by a read issued at edge k+1. Writes to this register have no effect.
- R7: Plane m (0, 1 or 2) of bank b sits at 32·S+4·(m+S·b). Bit i of plane m holds bit m of the function code of pin 32·b+i. The code appears on `pin_func_o[3p+2:3p]`.
- R8: A pin with function code 0 drives `pin_out_o` and `pin_oe_o` from its output and enable registers. A pin with any nonzero code drives both outputs as 0.
- R9: Bits at or above NUM_PINS read as 0 and ignore writes.
- R10: The following accesses read as 0 and change nothing: addresses with nonzero low two bits, the interrupt and map area, and all addresses outside the decoded registers.
- R11: A write takes effect at the clock edge of its access cycle. Read data appears on `rdata_o` in the cycle after the read request. `rdata_o` is 0 in any cycle that follows a cycle without a read. Outputs stay stable when there is no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, one cycle after the request |
| pin_in_i | input | NUM_PINS | Pad input levels (asynchronous) |
| pin_out_o | output | NUM_PINS | Pad drive value for GPIO-mode pins |
| pin_oe_o | output | NUM_PINS | Pad output enable for GPIO-mode pins |
| pin_func_o | output | 3*NUM_PINS | Function code per pin, 3 bits each |

## Verification
A decode fault that sends a write to the wrong bank or plane shows up at the pin outputs. It appears at the next sample after the write edge, on pins that should not have changed. A corrupted plane bit shows as a wrong function code. It also shows as a GPIO pin that goes quiet or an alternate-function pin that still drives. Faults in the synchronizer depth and in the read path can only be seen through `rdata_o`. The bench therefore reads every register back one cycle after the request and times the input readback against the exact edge.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;
  // base byte offsets, each scaled by the bank count
  localparam int unsigned OFS_SET = 0;
  localparam int unsigned OFS_CLR = 4;
  localparam int unsigned OFS_OUT = 8;
  localparam int unsigned OFS_IN  = 12;
  localparam int unsigned OFS_OE  = 16;
  localparam int unsigned OFS_ALT = 32;
  localparam int unsigned NUM_PLANES = 3;

  typedef enum logic [3:0] {
    ACC_NONE, ACC_SET, ACC_CLR, ACC_OUT, ACC_IN, ACC_OE,
    ACC_ALT0, ACC_ALT1, ACC_ALT2
  } acc_kind_e;

  function automatic int unsigned bank_count(int unsigned pins);
    return 1 + (pins - 1) / 32;
  endfunction
endpackage

// File: rtl/pin_bank_decode.sv
module pin_bank_decode
  import pin_bank_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned BANK_W    = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [BANK_W-1:0] bank_o
);
  logic [31:0] word;
  logic        aligned;

  assign word    = 32'(addr_i[ADDR_W-1:2]);
  assign aligned = (addr_i[1:0] == 2'b00);

  always_comb begin
    kind_o = ACC_NONE;
    bank_o = '0;
    if (aligned) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (word == 32'(OFS_SET / 4 * NUM_BANKS + b)) begin kind_o = ACC_SET; bank_o = BANK_W'(b); end
        if (word == 32'(OFS_CLR / 4 * NUM_BANKS + b)) begin kind_o = ACC_CLR; bank_o = BANK_W'(b); end
        if (word == 32'(OFS_OUT / 4 * NUM_BANKS + b)) begin kind_o = ACC_OUT; bank_o = BANK_W'(b); end
        if (word == 32'(OFS_IN  / 4 * NUM_BANKS + b)) begin kind_o = ACC_IN;  bank_o = BANK_W'(b); end
        if (word == 32'(OFS_OE  / 4 * NUM_BANKS + b)) begin kind_o = ACC_OE;  bank_o = BANK_W'(b); end
        // three planes of one bank are consecutive words
        if (word == 32'(OFS_ALT / 4 * NUM_BANKS + 0 + NUM_BANKS * b)) begin kind_o = ACC_ALT0; bank_o = BANK_W'(b); end
        if (word == 32'(OFS_ALT / 4 * NUM_BANKS + 1 + NUM_BANKS * b)) begin kind_o = ACC_ALT1; bank_o = BANK_W'(b); end
        if (word == 32'(OFS_ALT / 4 * NUM_BANKS + 2 + NUM_BANKS * b)) begin kind_o = ACC_ALT2; bank_o = BANK_W'(b); end
      end
    end
  end
endmodule

// File: rtl/pin_bank_sync.sv
module pin_bank_sync #(
  parameter int unsigned WIDTH = 67
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      q_o    <= '0;
    end else begin
      meta_q <= d_i;
      q_o    <= meta_q;
    end
  end
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 67,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [31:0]           wdata_i,
  output logic [31:0]           rdata_o,
  input  logic [NUM_PINS-1:0]   pin_in_i,
  output logic [NUM_PINS-1:0]   pin_out_o,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic [3*NUM_PINS-1:0] pin_func_o
);
  localparam int unsigned NUM_BANKS = bank_count(NUM_PINS);
  localparam int unsigned BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int unsigned PAD_W     = NUM_BANKS * 32;

  acc_kind_e                      acc_kind;
  logic [BANK_W-1:0]              acc_bank;
  logic [PAD_W-1:0]               valid_mask;
  logic [PAD_W-1:0]               out_q, out_d, oe_q, oe_d, in_pad;
  logic [NUM_PLANES-1:0][PAD_W-1:0] alt_q, alt_d;
  logic [NUM_PINS-1:0]            in_sync;
  logic [31:0]                    rd_word;

  pin_bank_decode #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BANK_W(BANK_W)
  ) u_decode (
    .addr_i(addr_i), .kind_o(acc_kind), .bank_o(acc_bank)
  );

  pin_bank_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_in_i), .q_o(in_sync)
  );

  for (genvar p = 0; p < PAD_W; p++) begin : g_mask
    assign valid_mask[p] = (p < NUM_PINS);
  end

  always_comb begin
    in_pad                 = '0;
    in_pad[NUM_PINS-1:0]   = in_sync;
  end

  always_comb begin
    out_d = out_q;
    oe_d  = oe_q;
    alt_d = alt_q;
    if (req_i && we_i) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(acc_bank) == b) begin
          case (acc_kind)
            ACC_SET:  out_d[b*32 +: 32]    = out_q[b*32 +: 32] | wdata_i;
            ACC_CLR:  out_d[b*32 +: 32]    = out_q[b*32 +: 32] & ~wdata_i;
            ACC_OUT:  out_d[b*32 +: 32]    = wdata_i;
            ACC_OE:   oe_d[b*32 +: 32]     = wdata_i;
            ACC_ALT0: alt_d[0][b*32 +: 32] = wdata_i;
            ACC_ALT1: alt_d[1][b*32 +: 32] = wdata_i;
            ACC_ALT2: alt_d[2][b*32 +: 32] = wdata_i;
            default: ;
          endcase
        end
      end
    end
    out_d = out_d & valid_mask;
    oe_d  = oe_d & valid_mask;
    for (int m = 0; m < NUM_PLANES; m++) alt_d[m] = alt_d[m] & valid_mask;
  end

  always_comb begin
    rd_word = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(acc_bank) == b) begin
        case (acc_kind)
          ACC_SET, ACC_CLR, ACC_OUT: rd_word = out_q[b*32 +: 32];
          ACC_IN:   rd_word = in_pad[b*32 +: 32];
          ACC_OE:   rd_word = oe_q[b*32 +: 32];
          ACC_ALT0: rd_word = alt_q[0][b*32 +: 32];
          ACC_ALT1: rd_word = alt_q[1][b*32 +: 32];
          ACC_ALT2: rd_word = alt_q[2][b*32 +: 32];
          default:  rd_word = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q   <= '0;
      oe_q    <= '0;
      alt_q   <= '0;
      rdata_o <= '0;
    end else begin
      out_q   <= out_d;
      oe_q    <= oe_d;
      alt_q   <= alt_d;
      rdata_o <= (req_i && !we_i) ? rd_word : '0;
    end
  end

  // code 0 = GPIO; any other code hands the pad to an alternate function
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [2:0] func;
    assign func               = {alt_q[2][p], alt_q[1][p], alt_q[0][p]};
    assign pin_func_o[3*p +: 3] = func;
    assign pin_out_o[p]       = (func == 3'd0) & out_q[p];
    assign pin_oe_o[p]        = (func == 3'd0) & oe_q[p];
  end
endmodule

// File: rtl/pin_bank_ctrl_chk.sv
module pin_bank_ctrl_chk
  import pin_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 67,
  parameter int unsigned ADDR_W   = 10
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [ADDR_W-1:0]     addr_i,
  input logic [31:0]           wdata_i,
  input logic [31:0]           rdata_o,
  input logic [NUM_PINS-1:0]   pin_out_o,
  input logic [NUM_PINS-1:0]   pin_oe_o,
  input logic [3*NUM_PINS-1:0] pin_func_o
);
  localparam int unsigned NB = bank_count(NUM_PINS);

  logic [NUM_PINS-1:0] gpio_all;
  logic [31:0]         gpio_lo, out_lo;
  logic                wr_set0, wr_clr0;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_gpio
    assign gpio_all[p] = (pin_func_o[3*p +: 3] == 3'd0);
  end
  assign gpio_lo = 32'(gpio_all);
  assign out_lo  = 32'(pin_out_o);
  assign wr_set0 = req_i && we_i && (addr_i == ADDR_W'(OFS_SET * NB));
  assign wr_clr0 = req_i && we_i && (addr_i == ADDR_W'(OFS_CLR * NB));

  p_set_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set0 |=> ((out_lo & $past(wdata_i & gpio_lo)) == $past(wdata_i & gpio_lo)));

  p_set_keeps_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set0 |=> ((out_lo & ~$past(wdata_i)) == ($past(out_lo) & ~$past(wdata_i))));

  p_clear_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr0 |=> ((out_lo & $past(wdata_i)) == 32'd0));

  p_alt_gates_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pin_out_o & ~gpio_all) == '0) && ((pin_oe_o & ~gpio_all) == '0));

  p_idle_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> ($stable(pin_out_o) && $stable(pin_oe_o) && $stable(pin_func_o)));

  p_rdata_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> (rdata_o == 32'd0));
endmodule

bind pin_bank_ctrl pin_bank_ctrl_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_out_o(pin_out_o),
  .pin_oe_o(pin_oe_o), .pin_func_o(pin_func_o)
);

// File: tb/pin_bank_ctrl_test.sv
`timescale 1ns/1ps
module pin_bank_ctrl_test;
  localparam int NP = 67;
  localparam int AW = 10;
  localparam int NB = 1 + (NP - 1) / 32;
  localparam int PW = NB * 32;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b1;
  logic            req_i = 1'b0;
  logic            we_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic [NP-1:0]   pin_in_i = '0;
  logic [NP-1:0]   pin_out_o, pin_oe_o;
  logic [3*NP-1:0] pin_func_o;

  pin_bank_ctrl #(.NUM_PINS(NP), .ADDR_W(AW)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_in_i(pin_in_i),
    .pin_out_o(pin_out_o), .pin_oe_o(pin_oe_o), .pin_func_o(pin_func_o)
  );

  always #2.5 clk_i = ~clk_i;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic [PW-1:0] m_out = '0, m_oe = '0, vmask;
  logic [2:0][PW-1:0] m_alt = '0;

  initial for (int p = 0; p < PW; p++) vmask[p] = (p < NP);

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] a_std(int base, int b);
    return AW'(base * NB + 4 * b);
  endfunction
  function automatic logic [AW-1:0] a_alt(int m, int b);
    return AW'(32 * NB + 4 * (m + NB * b));
  endfunction

  function automatic logic [255:0] e_func();
    logic [255:0] e = '0;
    for (int p = 0; p < NP; p++) e[3*p +: 3] = {m_alt[2][p], m_alt[1][p], m_alt[0][p]};
    return e;
  endfunction
  function automatic logic [255:0] e_out(bit oe);
    logic [255:0] e = '0;
    for (int p = 0; p < NP; p++)
      if ({m_alt[2][p], m_alt[1][p], m_alt[0][p]} == 3'd0) e[p] = oe ? m_oe[p] : m_out[p];
    return e;
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask
  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i); req_i = 0;
    chk(tag, 256'(rdata_o), 256'(exp));
  endtask
  task automatic pins(input string tag);
    chk({tag, " pin_out"}, 256'(pin_out_o), e_out(0));
    chk({tag, " pin_oe"}, 256'(pin_oe_o), e_out(1));
    chk({tag, " pin_func"}, 256'(pin_func_o), e_func());
  endtask

  task automatic w_set(int b, logic [31:0] d);
    wr(a_std(0, b), d); m_out[b*32 +: 32] |= d; m_out &= vmask;
  endtask
  task automatic w_clr(int b, logic [31:0] d);
    wr(a_std(4, b), d); m_out[b*32 +: 32] &= ~d;
  endtask
  task automatic w_out(int b, logic [31:0] d);
    wr(a_std(8, b), d); m_out[b*32 +: 32] = d; m_out &= vmask;
  endtask
  task automatic w_oe(int b, logic [31:0] d);
    wr(a_std(16, b), d); m_oe[b*32 +: 32] = d; m_oe &= vmask;
  endtask
  task automatic w_alt(int m, int b, logic [31:0] d);
    wr(a_alt(m, b), d); m_alt[m][b*32 +: 32] = d; m_alt[m] &= vmask;
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    logic [NP-1:0] lvl;
    #1 rst_ni = 0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset pin_out", 256'(pin_out_o), '0);
    chk("R1 reset pin_oe", 256'(pin_oe_o), '0);
    chk("R1 reset pin_func", 256'(pin_func_o), '0);
    chk("R1 reset rdata", 256'(rdata_o), '0);
    rst_ni = 1;
    @(negedge clk_i);
    rd(a_std(8, 0), 32'h0, "R1 out reg after reset");

    // R2: set accumulates, zeros keep
    for (int b = 0; b < NB; b++) begin
      w_set(b, 32'h0F0F_00A5 ^ (32'h1111_1111 * b));
      w_set(b, 32'h3000_0100 << b);
      rd(a_std(0, b), m_out[b*32 +: 32], "R2 set readback");
      pins("R2");
    end
    // R3: clear
    for (int b = 0; b < NB; b++) begin
      w_clr(b, 32'h0F00_0081);
      rd(a_std(4, b), m_out[b*32 +: 32], "R3 clear readback");
      pins("R3");
    end
    // R4: direct output sweep
    for (int k = 0; k < 6; k++) begin
      logic [31:0] pat;
      pat = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : (k == 2) ? 32'h5555_5555 :
            (k == 3) ? 32'hAAAA_AAAA : (32'h1 << (k * 7));
      for (int b = 0; b < NB; b++) w_out(b, pat ^ b);
      for (int b = 0; b < NB; b++) rd(a_std(8, b), m_out[b*32 +: 32], "R4 out readback");
      pins("R4");
    end
    // R5: output enable
    for (int k = 0; k < 4; k++) begin
      for (int b = 0; b < NB; b++) w_oe(b, 32'hC3A5_5A3C >> (k + b));
      for (int b = 0; b < NB; b++) rd(a_std(16, b), m_oe[b*32 +: 32], "R5 oe readback");
      pins("R5");
    end
    // R6: synchronized input
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < NP; p++) lvl[p] = ((p * 3 + k) % 5) < 2;
      @(negedge clk_i); pin_in_i = lvl;
      repeat (3) @(negedge clk_i);
      for (int b = 0; b < NB; b++) rd(a_std(12, b), 32'(lvl >> (32 * b)), "R6 input readback");
    end
    begin
      logic [NP-1:0] old;
      old = pin_in_i;
      @(negedge clk_i); pin_in_i = ~old;
      rd(a_std(12, 0), 32'(old), "R6 one cycle too early");
      rd(a_std(12, 0), 32'(~old), "R6 after two flops");
      wr(a_std(12, 0), 32'h1234_5678);
      rd(a_std(12, 0), 32'(~old), "R6 write to input ignored");
      pins("R6 write to input");
    end
    // R7: function planes, codes (p+k)%8 for every k
    for (int k = 0; k < 8; k++) begin
      for (int b = 0; b < NB; b++)
        for (int m = 0; m < 3; m++) begin
          logic [31:0] d;
          for (int i = 0; i < 32; i++) d[i] = ((((b * 32 + i) + k) % 8) >> m) & 1;
          w_alt(m, b, d);
        end
      pins("R7 R8 codes");
      rd(a_alt(k % 3, k % NB), m_alt[k % 3][(k % NB)*32 +: 32], "R7 plane readback");
    end
    // R8: all drive bits on, mixed codes then all GPIO
    for (int b = 0; b < NB; b++) begin w_out(b, '1); w_oe(b, '1); end
    pins("R8 mixed gating");
    for (int b = 0; b < NB; b++) for (int m = 0; m < 3; m++) w_alt(m, b, '0);
    pins("R8 all gpio");
    chk("R8 all gpio drive", 256'(pin_out_o), 256'({NP{1'b1}}));
    // R9: unimplemented bits of last bank
    rd(a_std(8, NB - 1), 32'(vmask >> (32 * (NB - 1))), "R9 out upper bits");
    rd(a_std(16, NB - 1), 32'(vmask >> (32 * (NB - 1))), "R9 oe upper bits");
    w_alt(1, NB - 1, '1);
    rd(a_alt(1, NB - 1), 32'(vmask >> (32 * (NB - 1))), "R9 plane upper bits");
    pins("R9");
    w_alt(1, NB - 1, '0);
    // R10: unmapped and misaligned
    for (int b = 0; b < NB; b++) begin
      wr(AW'(20 * NB + 4 * b), '1);
      rd(AW'(20 * NB + 4 * b), 32'h0, "R10 interrupt area");
    end
    wr(AW'(32 * NB + 12 * NB), '1);
    rd(AW'(32 * NB + 12 * NB), 32'h0, "R10 past planes");
    wr(a_std(4, 0) + AW'(1), '1);
    rd(a_std(8, 0) + AW'(2), 32'h0, "R10 misaligned read");
    pins("R10 no effect");
    // R11: write visible right after its edge, idle rdata zero
    w_out(0, 32'h0000_00F0);
    chk("R11 write edge", 256'(pin_out_o), e_out(0));
    chk("R11 idle rdata", 256'(rdata_o), '0);
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R11 watchdog actual=hung expected=done");
      report();
      $finish;
    end
  end
endmodule